// File: doc/BRIEF.md
# Plateau-Sampled Overvoltage Latch

This block guards a quasi-resonant flyback controller against an output overvoltage. After every turn-off of the power switch, the voltage reflected on the auxiliary winding settles into a flat plateau that tracks the output. An external comparator reports whether that plateau sits above the trip level, which is set to 7.2 V at the sense pin by a 5.0 V reference behind a divide-by-1.44 network. The block samples this comparator flag once per off-period. The sample is taken at a fixed delay after the gate drive falls: 4.5 us for the slow variant and 1.5 us for the fast variant. By then the leakage-inductance ringing has died away. The delay is converted to clock cycles from the clock-frequency parameter.

A single high sample sets a latch that asks the fault sequencer to stop all switching. While the latch is set, the self-supply keeps cycling the supply rail between 5.3 V and 12 V. The latch ignores later samples and the reset of the surrounding logic. It clears only when a supply-reset flag reports that the rail has collapsed below about 4 V, which happens when mains power is removed. An external shutdown source, such as a thermistor, can force the sense pin above the threshold. It then trips the same latch through the same sampling path.

Top module: `ovl_plateau_latch`

## Requirements
- R1: With the drive low, the comparator flag is sampled at the clock edge that is exactly SAMPLE_CYC edges after the first edge that sees the drive low. SAMPLE_CYC is CLK_HZ times 4.5 us, or times 1.5 us when VARIANT_B is 1, with a minimum of 1. A high sample sets `latchOff` after that edge.
- R2: The flag is ignored at every other edge: during the on-time, before the sample edge and after it, within the same off-period.
- R3: If the drive is seen high at or before the sample edge, no sample is taken for that off-period.
- R4: Once set, `latchOff` stays high whatever later samples show, and also while `rstN` is low.
- R5: `supplyLow` high clears `latchOff` at once, without waiting for a clock edge. While `supplyLow` is high, a high sample cannot set the latch. `latchOff` reads 0 out of power-up, while `supplyLow` is held high.
- R6: `plateauHigh` holds the result of the most recent sample. It is cleared at the edge that detects a turn-off, and it is cleared while `rstN` is low.
- R7: A flag held high continuously trips the latch at the first off-period whose sample edge is reached with the drive still low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock at CLK_HZ |
| rstN | input | 1 | Active-low reset of the timing and status logic (does not clear the latch) |
| gateDrv | input | 1 | Gate-drive state, 1 = switch on |
| ovpFlag | input | 1 | Plateau comparator output, 1 = above trip level |
| supplyLow | input | 1 | Supply-reset flag, 1 = rail below the clear level; asynchronous clear of the latch |
| latchOff | output | 1 | Permanent shutdown request to the fault sequencer |
| plateauHigh | output | 1 | Result of the latest plateau sample |

## Verification
Several properties are checked on every cycle by the assertions:
- The delay counter never passes its terminal count.
- A turn-on during the wait returns the timer to idle.
- Samples are never taken on consecutive edges.
- Every rise of the latch is traced to a sample strobe that coincides with a high flag.
- The latch holds until the supply flag is raised, and it is low whenever that flag is high.

Some behaviours depend on the exact position of the sample edge and only the bench scenarios can show them:
- A flag pulse one edge early or one edge late is ignored.
- A turn-on landing exactly on the sample edge suppresses the sample.
- The latch survives a pulse on `rstN`.
- The supply flag wins over a coincident high sample.

// File: rtl/ovl_pkg.sv
package ovl_pkg;

  typedef struct packed {
    logic arm;   // turn-off detected, off-period begins
    logic take;  // capture the comparator flag this edge
  } ovlStrobe_t;

  function automatic int sampleCycles(input longint clkHz, input bit variantB);
    longint delayNs;
    longint cyc;
    delayNs = variantB ? 64'd1500 : 64'd4500;
    cyc = (clkHz * delayNs) / 64'd1000000000;
    if (cyc < 64'd1) cyc = 64'd1;
    return int'(cyc);
  endfunction

endpackage

// File: rtl/ovl_timer.sv
module ovl_timer
  import ovl_pkg::*;
#(
  parameter int SAMPLE_CYC = 45
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       gateDrv,
  output ovlStrobe_t stb
);

  localparam int CNT_W = $clog2(SAMPLE_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SAMPLE_CYC);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  typedef enum logic {ST_IDLE, ST_WAIT} tmrState_t;

  tmrState_t        state;
  logic [CNT_W-1:0] cnt;
  logic             drvPrev;

  always_comb begin
    stb.arm  = drvPrev & ~gateDrv;
    stb.take = (state == ST_WAIT) & ~gateDrv & (cnt == CNT_LAST);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      drvPrev <= 1'b0;
    end else begin
      drvPrev <= gateDrv;
      case (state)
        ST_IDLE: begin
          if (stb.arm) begin
            state <= ST_WAIT;
            cnt   <= CNT_ONE;
          end
        end
        ST_WAIT: begin
          if (gateDrv) begin
            state <= ST_IDLE;
            cnt   <= '0;
          end else if (cnt == CNT_LAST) begin
            state <= ST_IDLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + CNT_ONE;
          end
        end
        default: begin
          state <= ST_IDLE;
          cnt   <= '0;
        end
      endcase
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= CNT_LAST); // R1

  AST_ABORT_ON_TURN_ON: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT) && gateDrv |=> (state == ST_IDLE)); // R3

  AST_ONE_SAMPLE: assert property (@(posedge clk) disable iff (!rstN)
    stb.take |=> !stb.take); // R2

endmodule

// File: rtl/ovl_capture.sv
module ovl_capture
  import ovl_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       supplyLow,
  input  logic       ovpFlag,
  input  ovlStrobe_t stb,
  output logic       latchOff,
  output logic       plateauHigh
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      plateauHigh <= 1'b0;
    end else if (stb.arm) begin
      plateauHigh <= 1'b0;
    end else if (stb.take) begin
      plateauHigh <= ovpFlag;
    end
  end

  // Only a collapsed supply clears the shutdown request.
  always_ff @(posedge clk or posedge supplyLow) begin
    if (supplyLow) begin
      latchOff <= 1'b0;
    end else if (stb.take && ovpFlag) begin
      latchOff <= 1'b1;
    end
  end

  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (supplyLow)
    latchOff |=> latchOff); // R4

  AST_LATCH_SOURCE: assert property (@(posedge clk) disable iff (supplyLow)
    $rose(latchOff) |-> $past(stb.take && ovpFlag)); // R1

  AST_SUPPLY_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    supplyLow |-> !latchOff); // R5

  AST_STATUS_ARM: assert property (@(posedge clk) disable iff (!rstN)
    stb.arm |=> !plateauHigh); // R6

endmodule

// File: rtl/ovl_plateau_latch.sv
module ovl_plateau_latch
  import ovl_pkg::*;
#(
  parameter longint CLK_HZ    = 10000000,
  parameter bit     VARIANT_B = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic gateDrv,
  input  logic ovpFlag,
  input  logic supplyLow,
  output logic latchOff,
  output logic plateauHigh
);

  localparam int SAMPLE_CYC = sampleCycles(CLK_HZ, VARIANT_B);

  ovlStrobe_t stb;

  ovl_timer #(
    .SAMPLE_CYC(SAMPLE_CYC)
  ) uTimer (
    .clk     (clk),
    .rstN    (rstN),
    .gateDrv (gateDrv),
    .stb     (stb)
  );

  ovl_capture uCapture (
    .clk         (clk),
    .rstN        (rstN),
    .supplyLow   (supplyLow),
    .ovpFlag     (ovpFlag),
    .stb         (stb),
    .latchOff    (latchOff),
    .plateauHigh (plateauHigh)
  );

endmodule

// File: tb/ovl_plateau_latch_test.sv
module ovl_plateau_latch_test;

  localparam int     CLK_PERIOD = 10;
  localparam longint CLK_HZ     = 10000000;
  localparam bit     VARIANT_B  = 1'b0;
  // Sample delay in cycles: 4.5 us (or 1.5 us) at CLK_HZ
  localparam int S = int'((CLK_HZ / 1000) * (VARIANT_B ? 1500 : 4500) / 1000000);
  localparam int NONE = 9999;

  logic clk = 1'b0;
  logic rstN, gateDrv, ovpFlag, supplyLow;
  logic latchOff, plateauHigh;

  ovl_plateau_latch #(.CLK_HZ(CLK_HZ), .VARIANT_B(VARIANT_B)) uut (
    .clk(clk), .rstN(rstN), .gateDrv(gateDrv), .ovpFlag(ovpFlag),
    .supplyLow(supplyLow), .latchOff(latchOff), .plateauHigh(plateauHigh)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    int    due;
    bit    lat;
    bit    st;
    string tag;
  } expItem_t;

  expItem_t expQ[$];
  int  cyc = 0;
  int  checks = 0;
  int  fails = 0;
  bit  done = 1'b0;
  bit  model = 1'b0;
  bit  ovpHold = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: compares due items against the outputs, away from the clock edge
  always @(negedge clk) begin
    for (int i = expQ.size() - 1; i >= 0; i--) begin
      if (expQ[i].due == cyc) begin
        checks++;
        if (latchOff !== expQ[i].lat || plateauHigh !== expQ[i].st) begin
          fails++;
          $display("FAIL %s @cycle %0d: latchOff=%b plateauHigh=%b expected latchOff=%b plateauHigh=%b",
                   expQ[i].tag, cyc, latchOff, plateauHigh, expQ[i].lat, expQ[i].st);
        end
        expQ.delete(i);
      end
    end
  end

  task automatic pushExp(input int due, input bit lat, input bit st, input string tag);
    expItem_t it;
    it.due = due; it.lat = lat; it.st = st; it.tag = tag;
    expQ.push_back(it);
  endtask

  task automatic checkNext(input bit lat, input bit st, input string tag);
    pushExp(cyc + 1, lat, st, tag);
    @(negedge clk);
  endtask

  // One on-period then one off-period. earlyOn: cycles after turn-off to
  // raise the drive again (0 = never). ovpRel: flag pulse seen at sample
  // edge + ovpRel (NONE = no pulse). onOvp: flag level during on-time.
  task automatic runCycle(input int onCyc, input int earlyOn, input int ovpRel,
                          input bit onOvp, input string tag);
    int n, e, x;
    bit taken, val;
    gateDrv = 1'b1;
    ovpFlag = onOvp | ovpHold;
    repeat (onCyc) @(negedge clk);
    gateDrv = 1'b0;
    ovpFlag = ovpHold;
    n = cyc;
    e = n + 1 + S;
    x = e + ovpRel;
    taken = !(earlyOn > 0 && earlyOn <= S);
    val = ovpHold || (ovpRel == 0);
    pushExp(e - 1, model, 1'b0, tag);
    if (supplyLow) model = 1'b0;
    else if (taken && val) model = 1'b1;
    pushExp(e, model, taken && val, tag);
    pushExp(e + 2, model, taken && val, tag);
    while (cyc < e + 2) begin
      @(negedge clk);
      if (earlyOn > 0 && cyc == n + earlyOn) gateDrv = 1'b1;
      ovpFlag = ovpHold || (ovpRel != NONE && cyc == x - 1);
    end
    ovpFlag = ovpHold;
  endtask

  initial begin
    rstN = 1'b0; gateDrv = 1'b0; ovpFlag = 1'b0; supplyLow = 1'b1;
    repeat (4) @(negedge clk);
    checkNext(1'b0, 1'b0, "R5 power-up state");
    supplyLow = 1'b0;
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    runCycle(10, 0, NONE, 1'b1, "R2 flag during on-time ignored");
    runCycle(8, 0, -1, 1'b0, "R2 flag one edge before sample ignored (R1 boundary)");
    runCycle(8, 0, 1, 1'b0, "R2 flag one edge after sample ignored");

    ovpHold = 1'b1;
    runCycle(8, S, NONE, 1'b1, "R3 turn-on at sample edge suppresses sample");
    runCycle(8, 5, NONE, 1'b1, "R3 early turn-on suppresses sample");
    ovpHold = 1'b0;

    runCycle(12, 0, 0, 1'b0, "R1 flag on sample edge trips latch");
    runCycle(6, 0, NONE, 1'b0, "R4 latch holds, R6 status cleared by turn-off");

    rstN = 1'b0;
    repeat (3) @(negedge clk);
    checkNext(1'b1, 1'b0, "R4 latch survives rstN");
    rstN = 1'b1;

    supplyLow = 1'b1;
    model = 1'b0;
    checkNext(1'b0, 1'b0, "R5 supply flag clears latch");
    runCycle(6, 0, 0, 1'b0, "R5 supply flag beats coincident sample");
    supplyLow = 1'b0;
    checkNext(1'b0, 1'b1, "R5 latch stays clear after supply flag drops");

    ovpHold = 1'b1;
    runCycle(6, 3, NONE, 1'b1, "R7 held level, aborted off-period no trip");
    runCycle(6, 0, NONE, 1'b1, "R7 held external level trips latch");
    ovpHold = 1'b0;
    ovpFlag = 1'b0;

    repeat (4) @(negedge clk);
    if (expQ.size() != 0) begin
      checks++;
      fails++;
      $display("FAIL R1 scoreboard: %0d items unchecked, expected 0", expQ.size());
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R1 watchdog expired: done=0 expected done=1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule